// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block keeps a short queue of instruction bytes filled ahead of the decoder. It holds a 16-bit code segment and a 16-bit fetch offset, and builds a 20-bit physical byte address from them: the segment moved up by four bit positions, plus the offset. It reads one byte at a time over a request/acknowledge memory port and appends each returned byte to the queue. The decoder takes bytes only from the queue's pop port, never straight from memory. Refill and consumption overlap, so a steady consumer sees a continuous stream.

A taken branch is handled with the flush input. In the flush cycle the queue is emptied, a memory reply that arrives in that cycle is thrown away, and the new segment and offset are loaded. The next request goes to the new target. The parameter `WIDE_BUS` sets the queue depth: four bytes for a narrow-bus build and six for a wide-bus build.

Top module: `seg_prefetch_unit`

## Requirements
- R1: `mem_addr_o` equals segment×16 + offset, taken modulo 2^20. Segment 1007h with offset 2222h gives 12292h, and segment FFFFh with offset 0010h gives 00000h.
- R2: The queue holds at most 4 bytes when `WIDE_BUS`=0 and at most 6 when `WIDE_BUS`=1. `q_count_o` never goes above that depth.
- R3: A request is raised only when the queue will have a free slot. While the queue is full, `mem_req_o` is low. Once raised, `mem_req_o` stays high with `mem_addr_o` unchanged until `mem_ack_i` is seen or a flush occurs.
- R4: Each accepted byte (`mem_req_o` and `mem_ack_i` high in the same cycle, no flush) advances the offset by one. The offset wraps from FFFFh to 0000h and the segment does not change.
- R5: The pop port delivers bytes in the order they were fetched. `q_byte_o` is the oldest byte. `q_valid_o` is high only when the queue is non-empty, and a valid pop lowers the count by one.
- R6: A push and a pop in the same cycle leave `q_count_o` unchanged.
- R7: After a cycle with `flush_i` high, the queue is empty. A pop or a reply in that cycle has no effect. The next request uses `flush_cs_i`/`flush_ip_i`.
- R8: During reset and in the first cycle after it, the queue is empty and no request is pending. The first request fetches from the reset segment FFFFh and offset 0000h, which is address FFFF0h.
- R9: After a pop from a full queue, a new request is raised in the next cycle at the next sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard queue, load new fetch target |
| flush_cs_i | input | 16 | New code segment on flush |
| flush_ip_i | input | 16 | New fetch offset on flush |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 20 | Physical byte address |
| mem_ack_i | input | 1 | Read reply strobe, data valid in the same cycle |
| mem_data_i | input | 8 | Returned byte |
| pop_i | input | 1 | Decoder takes the head byte |
| q_valid_o | output | 1 | Head byte is valid |
| q_byte_o | output | 8 | Oldest queued byte |
| q_count_o | output | 3 | Bytes currently queued |

## Verification
The bound checker watches every cycle for the following: a request keeping its address stable while it waits, no request while the queue is full, the count staying within the depth, the queue emptying after a flush, and the count moving correctly on a pop alone or on a pop with a push. The bench scenarios cover the rest. They check the arithmetic of the physical address, including the 20-bit wrap and the example address. They check that the offset steps and wraps at 16 bits, and that bytes come out in order against a memory model. They also check that a reply arriving with a flush is dropped, and that fetching resumes when a full queue drains.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PA_W   = 20;
    localparam int BYTE_W = 8;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFF_W-1:0]  offset_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Fetch sequencer state: current target and outstanding request flag
    typedef struct packed {
        seg_t    cs;
        offset_t ip;
        logic    req;
    } fetch_state_t;

    function automatic int depth_for(bit wide);
        return wide ? 6 : 4;
    endfunction
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen
    import pf_pkg::*;
(
    input  seg_t    seg_i,
    input  offset_t off_i,
    output paddr_t  paddr_o
);
    localparam int SHIFT = PA_W - SEG_W;
    localparam int SUM_W = PA_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, seg_i, {SHIFT{1'b0}}} + {{(SUM_W-OFF_W){1'b0}}, off_i};
        paddr_o = sum[PA_W-1:0];   // carry out of bit 19 is dropped
    end
endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o,
    output logic             room_next_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic     pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        pop_ok  = pop_i && (s_q.cnt != '0);
        push_ok = push_i && ((s_q.cnt != FULL_CNT) || pop_ok);
        if (clear_i) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (push_ok) begin
                s_d.slot[s_d.wr] = din_i;
                s_d.wr           = ptr_step(s_q.wr);
            end
            if (pop_ok) begin
                s_d.rd = ptr_step(s_q.rd);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
        room_next_o = (s_d.cnt < FULL_CNT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout_o  = s_q.slot[s_q.rd];
    assign valid_o = (s_q.cnt != '0);
    assign count_o = s_q.cnt;
endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl
    import pf_pkg::*;
#(
    parameter seg_t    RST_CS = 16'hFFFF,
    parameter offset_t RST_IP = 16'h0000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush_i,
    input  seg_t    flush_cs_i,
    input  offset_t flush_ip_i,
    input  logic    ack_i,
    input  logic    room_next_i,
    output logic    req_o,
    output seg_t    cs_o,
    output offset_t ip_o,
    output logic    push_o
);
    fetch_state_t s_d, s_q;

    // A reply counts only when it answers a live request outside a flush
    assign push_o = s_q.req && ack_i && !flush_i;

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            s_d.cs  = flush_cs_i;
            s_d.ip  = flush_ip_i;
            s_d.req = 1'b1;
        end else begin
            if (s_q.req && ack_i) begin
                s_d.ip = s_q.ip + 1'b1;
            end
            if (s_q.req && !ack_i) begin
                s_d.req = 1'b1;
            end else begin
                s_d.req = room_next_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cs: RST_CS, ip: RST_IP, req: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o = s_q.req;
    assign cs_o  = s_q.cs;
    assign ip_o  = s_q.ip;
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
    import pf_pkg::*;
#(
    parameter bit          WIDE_BUS = 1'b0,
    parameter logic [15:0] RST_CS   = 16'hFFFF,
    parameter logic [15:0] RST_IP   = 16'h0000,
    localparam int         QDEPTH   = depth_for(WIDE_BUS),
    localparam int         CNT_W    = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [15:0]      flush_cs_i,
    input  logic [15:0]      flush_ip_i,
    output logic             mem_req_o,
    output logic [19:0]      mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [7:0]       mem_data_i,
    input  logic             pop_i,
    output logic             q_valid_o,
    output logic [7:0]       q_byte_o,
    output logic [CNT_W-1:0] q_count_o
);
    seg_t    cur_cs;
    offset_t cur_ip;
    logic    push, room_next;

    pf_fetch_ctrl #(
        .RST_CS (RST_CS),
        .RST_IP (RST_IP)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .flush_cs_i  (flush_cs_i),
        .flush_ip_i  (flush_ip_i),
        .ack_i       (mem_ack_i),
        .room_next_i (room_next),
        .req_o       (mem_req_o),
        .cs_o        (cur_cs),
        .ip_o        (cur_ip),
        .push_o      (push)
    );

    pf_addr_gen u_addr (
        .seg_i   (cur_cs),
        .off_i   (cur_ip),
        .paddr_o (mem_addr_o)
    );

    pf_byte_queue #(
        .DEPTH (QDEPTH),
        .W     (BYTE_W),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (flush_i),
        .push_i      (push),
        .din_i       (mem_data_i),
        .pop_i       (pop_i),
        .dout_o      (q_byte_o),
        .valid_o     (q_valid_o),
        .count_o     (q_count_o),
        .room_next_o (room_next)
    );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter bit  WIDE_BUS = 1'b0,
    localparam int DEPTH    = pf_pkg::depth_for(WIDE_BUS),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             mem_req_o,
    input logic [19:0]      mem_addr_o,
    input logic             mem_ack_i,
    input logic             pop_i,
    input logic             q_valid_o,
    input logic [CNT_W-1:0] q_count_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !flush_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_full_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count_o == FULL) |-> !mem_req_o);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_count_o <= FULL);

    assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && q_valid_o && !(mem_req_o && mem_ack_i) && !flush_i)
        |=> (q_count_o == $past(q_count_o) - 1'b1));

    assert_pushpop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && q_valid_o && mem_req_o && mem_ack_i && !flush_i) |=> $stable(q_count_o));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (q_count_o == '0 && !q_valid_o));
endmodule

bind seg_prefetch_unit pf_checker #(.WIDE_BUS(WIDE_BUS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .pop_i      (pop_i),
    .q_valid_o  (q_valid_o),
    .q_count_o  (q_count_o)
);

// File: tb/test_seg_prefetch_unit.sv
`timescale 1ns/1ps
module test_seg_prefetch_unit;
    localparam bit BW    = 1'b0;
    localparam int DEPTH = BW ? 6 : 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_cs_i = '0, flush_ip_i = '0;
    logic        mem_req_o;
    logic [19:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [7:0]  mem_data_i = '0;
    logic        pop_i = 1'b0;
    logic        q_valid_o;
    logic [7:0]  q_byte_o;
    logic [2:0]  q_count_o;

    int total = 0, bad = 0, cycles = 0, wait_cnt = 0, ack_gap = 0;
    bit ack_en = 0, pop_en = 0, flush_req = 0, ack_on_flush = 0;
    logic [15:0] fcs = 16'hFFFF, fip = 16'h0000, nxt_cs, nxt_ip;
    logic [19:0] held_addr;
    logic [7:0]  sb[$];

    always #4 clk = ~clk;   // 125 MHz

    seg_prefetch_unit #(.WIDE_BUS(BW)) i_seg_prefetch_unit (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .flush_cs_i(flush_cs_i), .flush_ip_i(flush_ip_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i),
        .pop_i(pop_i), .q_valid_o(q_valid_o), .q_byte_o(q_byte_o),
        .q_count_o(q_count_o)
    );

    function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
        logic [19:0] r;
        r = {s, 4'h0} + {4'h0, o};
        return r;
    endfunction

    function automatic logic [7:0] mem_byte(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'hA};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o, input bit with_ack);
        @(posedge clk);
        nxt_cs = s; nxt_ip = o; ack_on_flush = with_ack; flush_req = 1;
        @(posedge clk);   // flush edge
    endtask

    // Driver (memory model) and monitor (pop scoreboard), all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush_req) begin
                flush_i = 1; flush_cs_i = nxt_cs; flush_ip_i = nxt_ip;
                pop_i = 1;   // must be ignored (R7)
                if (ack_on_flush && mem_req_o) begin
                    mem_ack_i = 1; mem_data_i = 8'hEE;
                end else begin
                    mem_ack_i = 0;
                end
                sb.delete();
                fcs = nxt_cs; fip = nxt_ip; wait_cnt = 0;
                flush_req = 0; ack_on_flush = 0;
            end else begin
                flush_i = 0;
                pop_i = pop_en;
                chk(!(q_valid_o && sb.size() == 0), "R5 valid while empty", q_valid_o, 0);
                if (pop_en && q_valid_o && sb.size() != 0) begin
                    chk(q_byte_o == sb[0], "R5 byte order", q_byte_o, sb[0]);
                    void'(sb.pop_front());
                end
                mem_ack_i = 0;
                if (ack_en && mem_req_o) begin
                    if (wait_cnt >= ack_gap) begin
                        chk(mem_addr_o == phys(fcs, fip), "R1 R4 fetch address", mem_addr_o, phys(fcs, fip));
                        mem_ack_i = 1;
                        mem_data_i = mem_byte(mem_addr_o);
                        sb.push_back(mem_byte(phys(fcs, fip)));
                        fip = fip + 16'd1;
                        wait_cnt = 0;
                    end else begin
                        wait_cnt++;
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk(q_valid_o == 0, "R8 reset valid", q_valid_o, 0);
        chk(q_count_o == 0, "R8 reset count", q_count_o, 0);
        chk(mem_req_o == 0, "R8 reset req", mem_req_o, 0);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        chk(mem_req_o == 1, "R8 first req", mem_req_o, 1);
        chk(mem_addr_o == 20'hFFFF0, "R8 R1 restart address", mem_addr_o, 20'hFFFF0);

        // Fill to depth with no consumer
        @(posedge clk); ack_en = 1;
        cyc(20);
        @(negedge clk);
        chk(q_count_o == DEPTH, "R2 full count", q_count_o, DEPTH);
        chk(mem_req_o == 0, "R3 no req when full", mem_req_o, 0);

        // Pop one from full, replies held off
        @(posedge clk); ack_en = 0; pop_en = 1;
        @(posedge clk); pop_en = 0;
        @(negedge clk);
        chk(q_count_o == DEPTH - 1, "R9 count after pop", q_count_o, DEPTH - 1);
        chk(mem_req_o == 1, "R9 req resumes", mem_req_o, 1);
        chk(mem_addr_o == phys(fcs, fip), "R9 next address", mem_addr_o, phys(fcs, fip));
        held_addr = mem_addr_o;
        cyc(3);
        @(negedge clk);
        chk(mem_req_o == 1 && mem_addr_o == held_addr, "R3 address held", mem_addr_o, held_addr);

        // Push and pop in one cycle
        @(posedge clk); ack_en = 1; pop_en = 1;
        @(posedge clk); ack_en = 0; pop_en = 0;
        @(negedge clk);
        chk(q_count_o == DEPTH - 1, "R6 push+pop count", q_count_o, DEPTH - 1);

        // Streaming with several reply latencies and pop patterns
        @(posedge clk); ack_en = 1; pop_en = 1; ack_gap = 0;
        cyc(150);
        ack_gap = 2;
        cyc(150);
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); pop_en = ~pop_en;
        end
        pop_en = 1; ack_gap = 0;

        // Branch to the worked example address
        do_flush(16'h1007, 16'h2222, 0);
        @(negedge clk);
        chk(mem_addr_o == 20'h12292, "R1 example address", mem_addr_o, 20'h12292);
        chk(q_count_o == 0, "R7 flushed count", q_count_o, 0);
        cyc(50);

        // Branch into 20-bit wrap
        do_flush(16'hFFFF, 16'h0010, 0);
        @(negedge clk);
        chk(mem_addr_o == 20'h00000, "R1 20-bit wrap", mem_addr_o, 20'h00000);
        cyc(50);

        // Offset wrap inside the segment
        do_flush(16'h2000, 16'hFFFE, 0);
        cyc(3);
        @(negedge clk);
        chk(mem_addr_o == 20'h20000 || mem_addr_o == 20'h20001, "R4 offset wrap", mem_addr_o, 20'h20000);
        cyc(60);

        // Reply coinciding with a flush is dropped
        ack_gap = 3;
        cyc(10);
        do_flush(16'h1234, 16'h0100, 1);
        @(negedge clk);
        chk(q_count_o == 0 && q_valid_o == 0, "R7 reply dropped on flush", q_count_o, 0);
        ack_gap = 0;
        cyc(60);

        // Drain
        @(posedge clk); ack_en = 0; pop_en = 1;
        cyc(20);
        @(negedge clk);
        chk(q_count_o == 0 && q_valid_o == 0, "R5 drained", q_count_o, 0);
        chk(sb.size() == 0, "R5 all expected bytes delivered", sb.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule